// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads translation entries from a two-level table held in memory, in the way a paging unit does when it handles a translation request. A request carries the virtual address and the access type: read or write, and user or supervisor. The walker reads the directory entry and then, in most cases, one table entry through a plain memory read port. It returns one response that holds either the physical address or a fault. The fault reports a cause and the level at which it was found.

Each directory entry can end the walk at the first level as a 4 MB page, provided the large-page input is set. Otherwise the directory entry points to a 4 KB table page. Permissions are checked on every level. The walker handles one walk at a time and goes back to idle after each response.

Top module: `pageWalker`

## Requirements
- R1: When `pagingOn` is low on acceptance, the response arrives the cycle after acceptance. It carries `rspPaddr` equal to the virtual address and no fault, and no memory read is issued.
- R2: The first read of a walk goes to `{dirBase, va[31:22], 2'b00}`.
- R3: For a 4 KB walk, the second read goes to `{pde[31:12], va[21:12], 2'b00}`. The result is `{pte[31:12], va[11:0]}`.
- R4: When `bigPageOn` is set and directory entry bit 7 is set, the walk uses one read only. The result is `{pde[31:22], va[21:0]}`.
- R5: When `bigPageOn` is low, directory entry bit 7 has no effect, and the entry is used as a pointer to a table.
- R6: An entry with bit 0 (present) clear gives `rspFault`=1 and `rspCause`=0. `rspLevel` is 0 for the directory and 1 for the table. A faulting response has `rspPaddr`=0. A successful response has cause 0 and level 0.
- R7: A user access needs bit 2 (user) set at both levels. A denial gives cause 1. The level is 0 if the directory entry denies and 1 if only the table entry denies.
- R8: A user write also needs bit 1 (writable) set at both levels, with the same level rule. Supervisor accesses ignore bits 1 and 2.
- R9: `rspWrite` and `rspUser` repeat the access type of the request.
- R10: `reqReady` is high only when the walker is idle. `memReqValid` and `memAddr` stay steady until `memReqReady`. The walker is idle again the cycle after `rspValid`.
- R11: During and right after reset, `reqReady`=1, `memReqValid`=0 and `rspValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle, request accepted |
| reqVaddr | input | 32 | Virtual address |
| reqWrite | input | 1 | 1 = write access |
| reqUser | input | 1 | 1 = user access |
| dirBase | input | 20 | Page number of the directory |
| pagingOn | input | 1 | Translation enable |
| bigPageOn | input | 1 | 4 MB page enable |
| memReqValid | output | 1 | Memory read request valid |
| memReqReady | input | 1 | Memory accepts the read |
| memAddr | output | 32 | Byte address of the entry |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Entry read from memory |
| rspValid | output | 1 | One-cycle response strobe |
| rspPaddr | output | 32 | Physical address, 0 on fault |
| rspFault | output | 1 | Translation failed |
| rspCause | output | 1 | 0 absent, 1 protection |
| rspLevel | output | 1 | 0 directory, 1 table |
| rspWrite | output | 1 | Echo of access type write bit |
| rspUser | output | 1 | Echo of access type user bit |

## Verification
The bench first targets the level rule for protection faults. A directory that denies while the table entry also denies must report level 0. A design that checks only the last entry would report level 1, or no fault where the table entry allows the access. Supervisor writes to read-only entries must succeed, and a design that always checks the writable bit would fault them. A directory entry with bit 7 set is walked with `bigPageOn` low, and it must fetch from the aliased table. A walker that ignores the enable would return a 4 MB result after a single read. A random memory stall exposes any walker that drops or changes the entry address before it is accepted.

// File: rtl/pageWalkPkg.sv
package pageWalkPkg;
  localparam int VA_W      = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int PN_W      = VA_W - OFF_W;
  localparam int BIG_OFF_W = OFF_W + IDX_W;
  localparam int BIG_PN_W  = VA_W - BIG_OFF_W;
  localparam int FLAG_P    = 0;
  localparam int FLAG_W    = 1;
  localparam int FLAG_U    = 2;
  localparam int FLAG_BIG  = 7;

  typedef enum logic [1:0] {OUT_OK, OUT_ABSENT, OUT_DENIED} outKind_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_REQ, ST_DIR_WAIT, ST_TBL_REQ, ST_TBL_WAIT, ST_DONE
  } walkState_t;

  typedef struct packed {
    logic     loadReq;
    logic     loadDir;
    logic     loadTbl;
    logic     addrTbl;
    logic     setOut;
    outKind_t outKind;
    logic     outLevel;
  } walkStrobe_t;

  function automatic logic accessDenied(input logic wFlag, input logic uFlag,
                                        input logic isWrite, input logic isUser);
    return isUser && (!uFlag || (isWrite && !wFlag));
  endfunction
endpackage

// File: rtl/walkCtrl.sv
module walkCtrl
  import pageWalkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        pagingOn,
  input  logic        memReqReady,
  input  logic        memRspValid,
  input  logic        rdPresent,
  input  logic        rdBig,
  input  logic        rdDeny,
  input  logic        dirDeny,
  output logic        reqReady,
  output logic        memReqValid,
  output logic        rspValid,
  output walkStrobe_t strobe
);
  walkState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext   = state;
    strobe      = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    rspValid    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          if (!pagingOn) begin
            strobe.setOut  = 1'b1;
            strobe.outKind = OUT_OK;
            stateNext      = ST_DONE;
          end else begin
            stateNext = ST_DIR_REQ;
          end
        end
      end
      ST_DIR_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNext = ST_DIR_WAIT;
      end
      ST_DIR_WAIT: begin
        if (memRspValid) begin
          strobe.loadDir = 1'b1;
          if (!rdPresent) begin
            strobe.setOut  = 1'b1;
            strobe.outKind = OUT_ABSENT;
            stateNext      = ST_DONE;
          end else if (rdBig) begin
            strobe.setOut  = 1'b1;
            strobe.outKind = rdDeny ? OUT_DENIED : OUT_OK;
            stateNext      = ST_DONE;
          end else begin
            stateNext = ST_TBL_REQ;
          end
        end
      end
      ST_TBL_REQ: begin
        strobe.addrTbl = 1'b1;
        memReqValid    = 1'b1;
        if (memReqReady) stateNext = ST_TBL_WAIT;
      end
      ST_TBL_WAIT: begin
        strobe.addrTbl = 1'b1;
        if (memRspValid) begin
          strobe.loadTbl = 1'b1;
          strobe.setOut  = 1'b1;
          stateNext      = ST_DONE;
          if (!rdPresent) begin
            strobe.outKind  = OUT_ABSENT;
            strobe.outLevel = 1'b1;
          end else if (dirDeny) begin
            strobe.outKind  = OUT_DENIED;
          end else if (rdDeny) begin
            strobe.outKind  = OUT_DENIED;
            strobe.outLevel = 1'b1;
          end else begin
            strobe.outKind  = OUT_OK;
          end
        end
      end
      ST_DONE: begin
        rspValid  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/walkDatapath.sv
module walkDatapath
  import pageWalkPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic              reqUser,
  input  logic [PN_W-1:0]   dirBase,
  input  logic              pagingOn,
  input  logic              bigPageOn,
  input  logic [VA_W-1:0]   memRspData,
  output logic [VA_W-1:0]   memAddr,
  output logic [VA_W-1:0]   rspPaddr,
  output logic              rspFault,
  output logic              rspCause,
  output logic              rspLevel,
  output logic              rspWrite,
  output logic              rspUser,
  output logic              rdPresent,
  output logic              rdBig,
  output logic              rdDeny,
  output logic              dirDeny
);
  logic [VA_W-1:0] vaReg;
  logic [PN_W-1:0] baseReg, pdePn, ptePn;
  logic            wrReg, usrReg, pgReg, bigEnReg;
  logic            pdeW, pdeU, pdeBig;
  outKind_t        outReg;
  logic            levelReg;
  logic            unusedRsp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg    <= '0;
      baseReg  <= '0;
      wrReg    <= 1'b0;
      usrReg   <= 1'b0;
      pgReg    <= 1'b0;
      bigEnReg <= 1'b0;
      pdePn    <= '0;
      pdeW     <= 1'b0;
      pdeU     <= 1'b0;
      pdeBig   <= 1'b0;
      ptePn    <= '0;
      outReg   <= OUT_OK;
      levelReg <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        vaReg    <= reqVaddr;
        baseReg  <= dirBase;
        wrReg    <= reqWrite;
        usrReg   <= reqUser;
        pgReg    <= pagingOn;
        bigEnReg <= bigPageOn;
      end
      if (strobe.loadDir) begin
        pdePn  <= memRspData[VA_W-1:OFF_W];
        pdeW   <= memRspData[FLAG_W];
        pdeU   <= memRspData[FLAG_U];
        pdeBig <= memRspData[FLAG_BIG];
      end
      if (strobe.loadTbl) ptePn <= memRspData[VA_W-1:OFF_W];
      if (strobe.setOut) begin
        outReg   <= strobe.outKind;
        levelReg <= strobe.outLevel;
      end
    end
  end

  // Decode of the entry currently on the read port
  assign rdPresent = memRspData[FLAG_P];
  assign rdBig     = bigEnReg && memRspData[FLAG_BIG];
  assign rdDeny    = accessDenied(memRspData[FLAG_W], memRspData[FLAG_U], wrReg, usrReg);
  assign dirDeny   = accessDenied(pdeW, pdeU, wrReg, usrReg);
  assign unusedRsp = ^{memRspData[OFF_W-1:FLAG_BIG+1], memRspData[FLAG_BIG-1:FLAG_U+1]};

  assign memAddr = strobe.addrTbl
                 ? {pdePn, vaReg[BIG_OFF_W-1:OFF_W], 2'b00}
                 : {baseReg, vaReg[VA_W-1:BIG_OFF_W], 2'b00};

  always_comb begin
    if (outReg != OUT_OK)          rspPaddr = '0;
    else if (!pgReg)               rspPaddr = vaReg;
    else if (bigEnReg && pdeBig)   rspPaddr = {pdePn[PN_W-1:PN_W-BIG_PN_W], vaReg[BIG_OFF_W-1:0]};
    else                           rspPaddr = {ptePn, vaReg[OFF_W-1:0]};
  end

  assign rspFault = (outReg != OUT_OK);
  assign rspCause = (outReg == OUT_DENIED);
  assign rspLevel = levelReg;
  assign rspWrite = wrReg;
  assign rspUser  = usrReg;
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import pageWalkPkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [31:0]     reqVaddr,
  input  logic            reqWrite,
  input  logic            reqUser,
  input  logic [19:0]     dirBase,
  input  logic            pagingOn,
  input  logic            bigPageOn,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic [31:0]     memAddr,
  input  logic            memRspValid,
  input  logic [31:0]     memRspData,
  output logic            rspValid,
  output logic [31:0]     rspPaddr,
  output logic            rspFault,
  output logic            rspCause,
  output logic            rspLevel,
  output logic            rspWrite,
  output logic            rspUser
);
  walkStrobe_t strobe;
  logic rdPresent, rdBig, rdDeny, dirDeny;

  walkCtrl uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .pagingOn(pagingOn),
    .memReqReady(memReqReady), .memRspValid(memRspValid),
    .rdPresent(rdPresent), .rdBig(rdBig), .rdDeny(rdDeny), .dirDeny(dirDeny),
    .reqReady(reqReady), .memReqValid(memReqValid), .rspValid(rspValid),
    .strobe(strobe)
  );

  walkDatapath uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser), .dirBase(dirBase),
    .pagingOn(pagingOn), .bigPageOn(bigPageOn), .memRspData(memRspData),
    .memAddr(memAddr), .rspPaddr(rspPaddr), .rspFault(rspFault),
    .rspCause(rspCause), .rspLevel(rspLevel), .rspWrite(rspWrite),
    .rspUser(rspUser), .rdPresent(rdPresent), .rdBig(rdBig),
    .rdDeny(rdDeny), .dirDeny(dirDeny)
  );
endmodule

// File: rtl/walkChecker.sv
module walkChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqVaddr,
  input logic        pagingOn,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic [31:0] memAddr,
  input logic        rspValid,
  input logic [31:0] rspPaddr,
  input logic        rspFault,
  input logic        rspCause,
  input logic        rspLevel
);
  // R1
  bypass_direct_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !pagingOn |=> rspValid && !rspFault && rspPaddr == $past(reqVaddr));
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memAddr));
  // R10
  single_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReqValid && !rspValid);
  // R10
  back_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady && !rspValid);
  // R6
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspPaddr == 32'h0);
  // R6
  ok_clean_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> !rspCause && !rspLevel);
endmodule

bind pageWalker walkChecker uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqVaddr(reqVaddr), .pagingOn(pagingOn), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memAddr(memAddr), .rspValid(rspValid),
  .rspPaddr(rspPaddr), .rspFault(rspFault), .rspCause(rspCause),
  .rspLevel(rspLevel)
);

// File: tb/tb_pageWalker.sv
`timescale 1ns/1ps
module tb_pageWalker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic [19:0] dirBase = '0;
  logic        pagingOn = 1'b0;
  logic        bigPageOn = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic [31:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid;
  logic [31:0] rspPaddr;
  logic        rspFault, rspCause, rspLevel, rspWrite, rspUser;

  int checks = 0;
  int fails = 0;
  int totalReads = 0;
  logic [31:0] mem [0:4095];
  logic [31:0] readLog [0:7];

  always #5 clk = ~clk;

  pageWalker dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .reqUser(reqUser),
    .dirBase(dirBase), .pagingOn(pagingOn), .bigPageOn(bigPageOn),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memAddr(memAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .rspValid(rspValid),
    .rspPaddr(rspPaddr), .rspFault(rspFault), .rspCause(rspCause),
    .rspLevel(rspLevel), .rspWrite(rspWrite), .rspUser(rspUser)
  );

  // Memory model: one-cycle read latency, random stalls on acceptance
  always @(posedge clk) begin
    memRspValid <= 1'b0;
    if (memReqValid && memReqReady) begin
      memRspValid <= 1'b1;
      memRspData  <= mem[memAddr[13:2]];
      readLog[totalReads % 8] <= memAddr;
      totalReads  <= totalReads + 1;
    end
  end

  always @(negedge clk) memReqReady <= ($urandom % 4) != 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Independent reference translation over the bench memory (dirBase = 0)
  task automatic refWalk(input logic [31:0] va, input logic wr, input logic usr,
                         input logic pg, input logic big,
                         output logic [31:0] pa, output logic fault, output logic cause,
                         output logic level, output int reads,
                         output logic [31:0] a0, output logic [31:0] a1);
    logic [31:0] pde, pte;
    logic dDeny, tDeny;
    pa = '0; fault = 0; cause = 0; level = 0; reads = 0; a0 = '0; a1 = '0;
    if (!pg) begin pa = va; return; end
    a0 = {dirBase, va[31:22], 2'b00};
    pde = mem[a0[13:2]];
    reads = 1;
    dDeny = usr && (!pde[2] || (wr && !pde[1]));
    if (!pde[0]) begin fault = 1; return; end
    if (big && pde[7]) begin
      if (dDeny) begin fault = 1; cause = 1; end
      else pa = {pde[31:22], va[21:0]};
      return;
    end
    a1 = {pde[31:12], va[21:12], 2'b00};
    pte = mem[a1[13:2]];
    reads = 2;
    tDeny = usr && (!pte[2] || (wr && !pte[1]));
    if (!pte[0]) begin fault = 1; level = 1; end
    else if (dDeny) begin fault = 1; cause = 1; end
    else if (tDeny) begin fault = 1; cause = 1; level = 1; end
    else pa = {pte[31:12], va[11:0]};
  endtask

  logic [31:0] gotPa;
  logic        gotFault, gotCause, gotLevel, gotWr, gotUsr, busySeen;
  int          gotReads;
  logic [31:0] gotA0, gotA1;

  task automatic runWalk(input logic [31:0] va, input logic wr, input logic usr,
                         input logic pg, input logic big);
    int startReads;
    @(negedge clk);
    reqVaddr = va; reqWrite = wr; reqUser = usr; pagingOn = pg; bigPageOn = big;
    startReads = totalReads;
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    busySeen = !reqReady;
    while (!rspValid) @(negedge clk);
    gotPa = rspPaddr; gotFault = rspFault; gotCause = rspCause;
    gotLevel = rspLevel; gotWr = rspWrite; gotUsr = rspUser;
    gotReads = totalReads - startReads;
    gotA0 = readLog[startReads % 8];
    gotA1 = readLog[(startReads + 1) % 8];
  endtask

  task automatic walkAndCompare(input logic [31:0] va, input logic wr, input logic usr,
                                input logic pg, input logic big);
    logic [31:0] ePa, eA0, eA1;
    logic eF, eC, eL;
    int eR;
    refWalk(va, wr, usr, pg, big, ePa, eF, eC, eL, eR, eA0, eA1);
    runWalk(va, wr, usr, pg, big);
    chk("R1 R3 R4 R5 paddr", gotPa, ePa);
    chk("R6 R7 R8 fault/cause/level", {29'd0, gotFault, gotCause, gotLevel}, {29'd0, eF, eC, eL});
    chk("R1 R4 R5 read count", gotReads, eR);
    if (eR > 0) chk("R2 directory address", gotA0, eA0);
    if (eR > 1) chk("R3 table address", gotA1, eA1);
    chk("R9 access echo", {30'd0, gotWr, gotUsr}, {30'd0, wr, usr});
  endtask

  // Directed vectors: {pg,big,wr,usr}, va, expected {fault,cause,level}, paddr, reads
  localparam int NV = 16;
  localparam logic [3:0]  V_CTL [NV] = '{4'b0000, 4'b1001, 4'b1011, 4'b1010, 4'b1000, 4'b1011,
    4'b1001, 4'b1001, 4'b1010, 4'b1111, 4'b1000, 4'b1111, 4'b1100, 4'b1110, 4'b1101, 4'b1001};
  localparam logic [31:0] V_VA [NV] = '{32'hDEADBEEF, 32'h00000ABC, 32'h00001123, 32'h00001123,
    32'h00003004, 32'h00400010, 32'h00401010, 32'h00800004, 32'h00800004, 32'h00C12345,
    32'h00C12345, 32'h01000000, 32'h01400000, 32'h01800123, 32'h01800123, 32'h00400000};
  localparam logic [2:0]  V_EXP [NV] = '{3'b000, 3'b000, 3'b111, 3'b000, 3'b101, 3'b110,
    3'b000, 3'b110, 3'b000, 3'b000, 3'b101, 3'b110, 3'b100, 3'b000, 3'b110, 3'b111};
  localparam logic [31:0] V_PA [NV] = '{32'hDEADBEEF, 32'h00100ABC, 32'h0, 32'h00101123, 32'h0,
    32'h0, 32'h00301010, 32'h0, 32'h00100004, 32'h00C12345, 32'h0, 32'h0, 32'h0,
    32'h00800123, 32'h0, 32'h0};
  localparam int V_RD [NV] = '{0, 2, 2, 2, 2, 2, 2, 2, 2, 1, 2, 1, 1, 1, 1, 2};

  initial begin
    begin : watchdog
      #1_500_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    mem[0] = 32'h00001007;  // table 1, P W U
    mem[1] = 32'h00002005;  // table 2, P U
    mem[2] = 32'h00001003;  // table 1, P W
    mem[3] = 32'h00C02087;  // 4 MB at 0x00C00000, P W U
    mem[4] = 32'h00C02085;  // 4 MB, P U
    mem[6] = 32'h00801083;  // 4 MB at 0x00800000, P W
    mem[7] = 32'h00002007;  // table 2, P W U
    for (int t = 0; t < 1024; t++) begin
      case (t % 4)
        0: mem[1024 + t] = {20'h00100 + 20'(t), 12'h007};
        1: mem[1024 + t] = {20'h00100 + 20'(t), 12'h005};
        2: mem[1024 + t] = {20'h00100 + 20'(t), 12'h003};
        default: mem[1024 + t] = 32'h0;
      endcase
      case (t % 4)
        0: mem[2048 + t] = {20'h00300 + 20'(t), 12'h001};
        1: mem[2048 + t] = {20'h00300 + 20'(t), 12'h007};
        2: mem[2048 + t] = 32'h0;
        default: mem[2048 + t] = {20'h00300 + 20'(t), 12'h005};
      endcase
    end

    // R11: reset state
    #12;
    chk("R11 reset reqReady", {31'd0, reqReady}, 32'd1);
    chk("R11 reset memReqValid", {31'd0, memReqValid}, 32'd0);
    chk("R11 reset rspValid", {31'd0, rspValid}, 32'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {30'd0, reqReady, rspValid}, 32'd2);

    // Directed table; vector 10 covers R5 (bit 7 set, large pages off)
    for (int i = 0; i < NV; i++) begin
      runWalk(V_VA[i], V_CTL[i][1], V_CTL[i][0], V_CTL[i][3], V_CTL[i][2]);
      chk("R1 R3 R4 R5 vector paddr", gotPa, V_PA[i]);
      chk("R6 R7 R8 vector fault/cause/level", {29'd0, gotFault, gotCause, gotLevel},
          {29'd0, V_EXP[i]});
      chk("R1 R4 R5 vector read count", gotReads, V_RD[i]);
      if (V_CTL[i][3]) chk("R10 busy during walk", {31'd0, busySeen}, 32'd1);
      chk("R9 vector echo", {30'd0, gotWr, gotUsr}, {30'd0, V_CTL[i][1], V_CTL[i][0]});
    end

    // R10: back to idle the cycle after the response
    @(negedge clk);
    chk("R10 idle after response", {31'd0, reqReady}, 32'd1);

    // Random walks against the reference, with and without large pages
    for (int n = 0; n < 400; n++) begin
      logic [31:0] va;
      va = {7'd0, 3'($urandom), 10'($urandom), 12'($urandom)};
      walkAndCompare(va, 1'($urandom), 1'($urandom), ($urandom % 8) != 0, 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule